// File: doc/BRIEF.md
# Bank-Group-Aware DRAM Column and Precharge Scheduler

This block picks, every clock cycle, at most one command for a single DRAM channel: a column read, a column write or a precharge. Each bank carries one pending request (valid, target row, read or write). The surrounding controller reports which banks are open, which row each open bank holds, and pulses a per-bank flag in the cycle it activates a row. Activation, refresh, address mapping and the data path all live outside this block.

Timing is enforced by down-counters at three levels. The channel level holds the short column spacing and the two bus-turnaround windows. Each bank group holds the long column spacing and a group-wide read-to-precharge window. Each bank holds its own row-to-column, row-active, read-to-precharge, write-to-precharge and precharge-recovery windows. Banks are grouped by the upper bits of the bank index. All timing values arrive on a static configuration bus, so one netlist serves several speed grades. When the long spacing and the group read-to-precharge value are zero, the group checks have no effect.

The scan over banks starts at a rotating priority pointer, which moves on by one after every cycle that issues a command. Service is therefore shared among banks that are ready at the same time.

Top module: `dram_col_sched`

## Requirements
- R1: At most one command issues per cycle, and only for a bank whose request is valid. Banks are scanned in the order (prio + k) mod NBANK, and the first eligible bank wins. `prio` is 0 after reset and advances by one, wrapping at NBANK, after each cycle that issues.
- R2: A bank belongs to group `bank >> log2(NBANK/NGROUP)`. NGROUP is a power of two that divides NBANK.
- R3: A read issues only to an active bank whose open row equals the requested row. The channel column counter, the bank row-to-column counter, the group long column counter and the write-to-read counter must all be zero.
- R4: A write issues only to an active bank whose open row equals the requested row. The channel column counter, the bank write row-to-column counter, the group long column counter and the read-to-write counter must all be zero.
- R5: Two column commands on the channel are at least `cfg_tccd` cycles apart. Two column commands in the same group are at least `cfg_tccdl` cycles apart.
- R6: A write is at least tRTW = CL + BL/2 + 2 - WL cycles after a read. A read is at least tWTR = WL + BL/2 + tCDLR cycles after a write.
- R7: A precharge issues only to an active bank whose open row differs from the requested row. It also waits for the following windows:
  - `cfg_tras` cycles after that bank's activation;
  - `cfg_twtp` cycles after a write to that bank;
  - BL/2 cycles after a read to that bank;
  - `cfg_trtpl` cycles after a read to any bank of its group.
- R8: After a precharge in cycle t, `bank_rp_busy` for that bank is high in cycles t+1 through t+tRP-1 and low from t+tRP on.
- R9: An activation pulse in cycle t allows a read from cycle t+tRCD and a write from cycle t+max(tRCD-(WL+1),0).
- R10: Reset clears every counter and the priority pointer. Every counter then counts down by one per cycle and stops at zero. A loaded value of k lets the gated command through k cycles later (the next cycle when k is 0 or 1).
- R11: `iss_cmd` encodes 2'b01 read, 2'b10 write and 2'b11 precharge. It is 2'b00 whenever `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NBANK | Pending request per bank |
| req_write | input | NBANK | 1 = write, 0 = read, per bank |
| req_row | input | NBANK*ROW_W | Requested row per bank, bank b at bits b*ROW_W |
| bank_active | input | NBANK | Bank holds an open row |
| bank_row | input | NBANK*ROW_W | Open row per bank |
| bank_act | input | NBANK | Activation pulse per bank |
| cfg_tccd | input | TW | Channel column spacing |
| cfg_tccdl | input | TW | Same-group column spacing |
| cfg_trcd | input | TW | Row-to-column delay |
| cfg_tras | input | TW | Minimum row active time |
| cfg_trp | input | TW | Precharge recovery |
| cfg_trtpl | input | TW | Group read-to-precharge delay |
| cfg_twtp | input | TW | Bank write-to-precharge delay |
| cfg_cl | input | TW | Read latency |
| cfg_wl | input | TW | Write latency |
| cfg_tcdlr | input | TW | Write-data-to-read delay |
| cfg_bl | input | TW | Burst length |
| iss_valid | output | 1 | A command issues this cycle |
| iss_bank | output | BW | Bank of the issued command |
| iss_cmd | output | 2 | Command code (see R11) |
| bank_rp_busy | output | NBANK | Precharge recovery in progress per bank |

## Verification
Each scenario places a first command and then a second request that only one timing window can block. The cycle in which the second command appears therefore shows which counter was charged and by how much.

- **Read followed by a read.** This is run to a bank in the same group and to a bank in the other group. The two gaps (tCCDL against tCCD) separate group-level spacing from channel-level spacing and confirm the group decode.
- **Mixed read and write pairs.** These show the two turnaround values. Because the pair spans two groups, the long spacing does not mask the turnaround.
- **Activation followed by a request.** An activation with a matching request measures the row-to-column delay. An activation with a mismatching request measures the row-active window.
- **Pending precharges.** A read before a precharge in the same group measures the group read-to-precharge window. A write before a precharge to the same bank measures the bank write-to-precharge window. Four banks that all want a precharge at once expose the rotation order.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_WR   = 2'b10,
    CMD_PRE  = 2'b11
  } dcmd_e;
endpackage

// File: rtl/dram_sched_cnt.sv
// Saturating timing down-counter: a load of k reads zero k cycles later.
module dram_sched_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          zero
);
  logic [CW-1:0] cnt_q, cnt_d, base;

  always_comb begin
    base  = load ? val : cnt_q;
    cnt_d = (base == '0) ? '0 : base - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/dram_sched_pick.sv
// Rotating-priority scan: first bank at or after prio with an eligible command.
module dram_sched_pick
  import dram_sched_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic [NBANK-1:0] rd_ok,
  input  logic [NBANK-1:0] wr_ok,
  input  logic [NBANK-1:0] pre_ok,
  input  logic [BW-1:0]    prio,
  output logic             pick_valid,
  output logic [BW-1:0]    pick_bank,
  output dcmd_e            pick_cmd
);
  always_comb begin
    pick_valid = 1'b0;
    pick_bank  = '0;
    pick_cmd   = CMD_NONE;
    for (int k = 0; k < NBANK; k++) begin
      int j;
      j = int'(prio) + k;
      if (j >= NBANK) j = j - NBANK;
      if (!pick_valid && (rd_ok[j] || wr_ok[j] || pre_ok[j])) begin
        pick_valid = 1'b1;
        pick_bank  = BW'(j);
        pick_cmd   = rd_ok[j] ? CMD_RD : (wr_ok[j] ? CMD_WR : CMD_PRE);
      end
    end
  end
endmodule

// File: rtl/dram_col_sched.sv
module dram_col_sched
  import dram_sched_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int NGROUP = 1,
  parameter int ROW_W  = 14,
  parameter int TW     = 6,
  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NBANK-1:0]       req_valid,
  input  logic [NBANK-1:0]       req_write,
  input  logic [NBANK*ROW_W-1:0] req_row,
  input  logic [NBANK-1:0]       bank_active,
  input  logic [NBANK*ROW_W-1:0] bank_row,
  input  logic [NBANK-1:0]       bank_act,
  input  logic [TW-1:0]          cfg_tccd,
  input  logic [TW-1:0]          cfg_tccdl,
  input  logic [TW-1:0]          cfg_trcd,
  input  logic [TW-1:0]          cfg_tras,
  input  logic [TW-1:0]          cfg_trp,
  input  logic [TW-1:0]          cfg_trtpl,
  input  logic [TW-1:0]          cfg_twtp,
  input  logic [TW-1:0]          cfg_cl,
  input  logic [TW-1:0]          cfg_wl,
  input  logic [TW-1:0]          cfg_tcdlr,
  input  logic [TW-1:0]          cfg_bl,
  output logic                   iss_valid,
  output logic [BW-1:0]          iss_bank,
  output logic [1:0]             iss_cmd,
  output logic [NBANK-1:0]       bank_rp_busy
);
  localparam int CW  = TW + 2;
  localparam int BPG = NBANK / NGROUP;
  localparam int TAG = (BPG > 1) ? $clog2(BPG) : 0;

  // derived timing values, clamped at zero
  logic [CW-1:0] t_rtw, t_wtr, t_rcdwr, t_bl2;
  always_comb begin
    int v_rtw, v_wtr, v_rcdwr;
    v_rtw   = int'(cfg_cl) + int'(cfg_bl) / 2 + 2 - int'(cfg_wl);
    v_wtr   = int'(cfg_wl) + int'(cfg_bl) / 2 + int'(cfg_tcdlr);
    v_rcdwr = int'(cfg_trcd) - (int'(cfg_wl) + 1);
    t_rtw   = (v_rtw   < 0) ? '0 : CW'(v_rtw);
    t_wtr   = (v_wtr   < 0) ? '0 : CW'(v_wtr);
    t_rcdwr = (v_rcdwr < 0) ? '0 : CW'(v_rcdwr);
    t_bl2   = CW'(cfg_bl >> 1);
  end

  // issue decode
  logic          pick_valid;
  logic [BW-1:0] pick_bank;
  dcmd_e         pick_cmd;
  logic          is_rd, is_wr, is_col;
  logic [BW-1:0] prio_q, prio_d;

  assign is_rd  = pick_valid && (pick_cmd == CMD_RD);
  assign is_wr  = pick_valid && (pick_cmd == CMD_WR);
  assign is_col = is_rd || is_wr;

  // channel-level counters
  logic ccd_z, rtw_z, wtr_z;
  dram_sched_cnt #(.CW(CW)) u_ccd (.clk(clk), .rst_n(rst_n), .load(is_col),
    .val(CW'(cfg_tccd)), .zero(ccd_z));
  dram_sched_cnt #(.CW(CW)) u_rtw (.clk(clk), .rst_n(rst_n), .load(is_rd),
    .val(t_rtw), .zero(rtw_z));
  dram_sched_cnt #(.CW(CW)) u_wtr (.clk(clk), .rst_n(rst_n), .load(is_wr),
    .val(t_wtr), .zero(wtr_z));

  // group-level counters
  logic [NGROUP-1:0] ccdl_z, rtpl_z;
  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    logic in_grp;
    assign in_grp = (int'(pick_bank) >> TAG) == g;
    dram_sched_cnt #(.CW(CW)) u_ccdl (.clk(clk), .rst_n(rst_n),
      .load(is_col && in_grp), .val(CW'(cfg_tccdl)), .zero(ccdl_z[g]));
    dram_sched_cnt #(.CW(CW)) u_rtpl (.clk(clk), .rst_n(rst_n),
      .load(is_rd && in_grp), .val(CW'(cfg_trtpl)), .zero(rtpl_z[g]));
  end

  // bank-level counters and eligibility
  logic [NBANK-1:0] rd_ok, wr_ok, pre_ok;
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int GI = b >> TAG;
    logic sel, row_hit, rcd_z, rcdwr_z, ras_z, rtp_z, wtp_z, rp_z;
    assign sel     = pick_valid && (int'(pick_bank) == b);
    assign row_hit = req_row[b*ROW_W +: ROW_W] == bank_row[b*ROW_W +: ROW_W];

    dram_sched_cnt #(.CW(CW)) u_rcd (.clk(clk), .rst_n(rst_n),
      .load(bank_act[b]), .val(CW'(cfg_trcd)), .zero(rcd_z));
    dram_sched_cnt #(.CW(CW)) u_rcdwr (.clk(clk), .rst_n(rst_n),
      .load(bank_act[b]), .val(t_rcdwr), .zero(rcdwr_z));
    dram_sched_cnt #(.CW(CW)) u_ras (.clk(clk), .rst_n(rst_n),
      .load(bank_act[b]), .val(CW'(cfg_tras)), .zero(ras_z));
    dram_sched_cnt #(.CW(CW)) u_rtp (.clk(clk), .rst_n(rst_n),
      .load(sel && is_rd), .val(t_bl2), .zero(rtp_z));
    dram_sched_cnt #(.CW(CW)) u_wtp (.clk(clk), .rst_n(rst_n),
      .load(sel && is_wr), .val(CW'(cfg_twtp)), .zero(wtp_z));
    dram_sched_cnt #(.CW(CW)) u_rp (.clk(clk), .rst_n(rst_n),
      .load(sel && (pick_cmd == CMD_PRE)), .val(CW'(cfg_trp)), .zero(rp_z));

    assign rd_ok[b]  = req_valid[b] && !req_write[b] && bank_active[b] && row_hit &&
                       ccd_z && rcd_z && ccdl_z[GI] && wtr_z;
    assign wr_ok[b]  = req_valid[b] && req_write[b] && bank_active[b] && row_hit &&
                       ccd_z && rcdwr_z && ccdl_z[GI] && rtw_z;
    assign pre_ok[b] = req_valid[b] && bank_active[b] && !row_hit &&
                       ras_z && wtp_z && rtp_z && rtpl_z[GI];
    assign bank_rp_busy[b] = !rp_z;
  end

  dram_sched_pick #(.NBANK(NBANK), .BW(BW)) u_pick (
    .rd_ok(rd_ok), .wr_ok(wr_ok), .pre_ok(pre_ok), .prio(prio_q),
    .pick_valid(pick_valid), .pick_bank(pick_bank), .pick_cmd(pick_cmd));

  // rotating priority pointer
  always_comb begin
    prio_d = prio_q;
    if (pick_valid) prio_d = (int'(prio_q) == NBANK - 1) ? '0 : prio_q + BW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prio_q <= '0;
    else        prio_q <= prio_d;
  end

  assign iss_valid = pick_valid;
  assign iss_bank  = pick_bank;
  assign iss_cmd   = pick_cmd;
endmodule

// File: rtl/dram_sched_chk.sv
module dram_sched_chk #(
  parameter int NBANK  = 4,
  parameter int NGROUP = 1,
  parameter int ROW_W  = 14,
  parameter int TW     = 6,
  parameter int BW     = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NBANK-1:0]       req_valid,
  input logic [NBANK-1:0]       req_write,
  input logic [NBANK*ROW_W-1:0] req_row,
  input logic [NBANK-1:0]       bank_active,
  input logic [NBANK*ROW_W-1:0] bank_row,
  input logic [TW-1:0]          cfg_tccd,
  input logic [TW-1:0]          cfg_tccdl,
  input logic                   iss_valid,
  input logic [BW-1:0]          iss_bank,
  input logic [1:0]             iss_cmd
);
  localparam int CW  = TW + 2;
  localparam int BPG = NBANK / NGROUP;
  localparam int TAG = (BPG > 1) ? $clog2(BPG) : 0;

  logic col;
  logic [CW-1:0] since_ch;
  logic [CW-1:0] since_grp [NGROUP];
  logic [CW-1:0] gap_grp;
  logic          b_act, b_hit, b_req, b_wr;

  assign col     = iss_valid && (iss_cmd == 2'b01 || iss_cmd == 2'b10);
  assign gap_grp = since_grp[int'(iss_bank) >> TAG];
  assign b_act   = bank_active[iss_bank];
  assign b_req   = req_valid[iss_bank];
  assign b_wr    = req_write[iss_bank];
  assign b_hit   = req_row[int'(iss_bank)*ROW_W +: ROW_W] ==
                   bank_row[int'(iss_bank)*ROW_W +: ROW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_ch <= '1;
    else if (col) since_ch <= CW'(1);
    else if (since_ch != '1) since_ch <= since_ch + CW'(1);
  end

  for (genvar g = 0; g < NGROUP; g++) begin : g_since
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_grp[g] <= '1;
      else if (col && ((int'(iss_bank) >> TAG) == g)) since_grp[g] <= CW'(1);
      else if (since_grp[g] != '1) since_grp[g] <= since_grp[g] + CW'(1);
    end
  end

  AST_ISS_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> b_req);  // R1
  AST_CCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> (since_ch >= CW'(cfg_tccd)));  // R5
  AST_CCDL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    col |-> (gap_grp >= CW'(cfg_tccdl)));  // R5
  AST_RD_ROW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == 2'b01) |-> (b_act && b_hit && !b_wr));  // R3
  AST_WR_ROW_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == 2'b10) |-> (b_act && b_hit && b_wr));  // R4
  AST_PRE_ROW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == 2'b11) |-> (b_act && !b_hit));  // R7
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> (iss_cmd == 2'b00));  // R11
endmodule

bind dram_col_sched dram_sched_chk #(
  .NBANK(NBANK), .NGROUP(NGROUP), .ROW_W(ROW_W), .TW(TW), .BW(BW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_row(req_row), .bank_active(bank_active), .bank_row(bank_row),
  .cfg_tccd(cfg_tccd), .cfg_tccdl(cfg_tccdl), .iss_valid(iss_valid),
  .iss_bank(iss_bank), .iss_cmd(iss_cmd)
);

// File: tb/dram_col_sched_bench.sv
module dram_col_sched_bench;
  localparam int NB = 4;
  localparam int NG = 2;
  localparam int RW = 8;
  localparam int TW = 6;
  localparam int BW = 2;
  localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_PRE = 2'b11;

  logic clk = 1'b0;
  logic rst_n;
  logic [NB-1:0] req_valid, req_write, bank_active, bank_act, bank_rp_busy;
  logic [NB*RW-1:0] req_row, bank_row;
  logic [TW-1:0] cfg_tccd, cfg_tccdl, cfg_trcd, cfg_tras, cfg_trp, cfg_trtpl,
                 cfg_twtp, cfg_cl, cfg_wl, cfg_tcdlr, cfg_bl;
  logic iss_valid;
  logic [BW-1:0] iss_bank;
  logic [1:0] iss_cmd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_col_sched #(.NBANK(NB), .NGROUP(NG), .ROW_W(RW), .TW(TW)) u_dram_col_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .bank_active(bank_active), .bank_row(bank_row),
    .bank_act(bank_act), .cfg_tccd(cfg_tccd), .cfg_tccdl(cfg_tccdl),
    .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .cfg_trtpl(cfg_trtpl), .cfg_twtp(cfg_twtp), .cfg_cl(cfg_cl), .cfg_wl(cfg_wl),
    .cfg_tcdlr(cfg_tcdlr), .cfg_bl(cfg_bl), .iss_valid(iss_valid),
    .iss_bank(iss_bank), .iss_cmd(iss_cmd), .bank_rp_busy(bank_rp_busy));

  // timing set: tRTW = 5+2+2-2 = 7, tWTR = 2+2+1 = 5, tRCDWR = 0
  localparam int T_CCD = 2, T_CCDL = 4, T_RCD = 3, T_RAS = 5, T_RP = 3,
                 T_RTPL = 3, T_WTP = 4, T_RTW = 7, T_WTR = 5;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_valid = '0; req_write = '0; req_row = '0;
    bank_active = '0; bank_row = '0; bank_act = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clr();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic open_row(input int b, input int row);
    bank_active[b] = 1'b1;
    bank_row[b*RW +: RW] = RW'(row);
  endtask

  task automatic rq(input int b, input bit wr, input int row);
    req_valid[b] = 1'b1;
    req_write[b] = wr;
    req_row[b*RW +: RW] = RW'(row);
  endtask

  // Called just after a negedge with inputs set for cycle 'start'.
  // Waits for the first issue and checks its cycle, bank and command.
  task automatic expect_iss(input int start, input int exp_at, input int exp_bank,
                            input logic [1:0] exp_cmd, input string tag);
    int at = -1;
    int bk = -1;
    int cm = -1;
    for (int c = start; c < start + 40; c++) begin
      #1;
      if (iss_valid) begin
        at = c; bk = int'(iss_bank); cm = int'(iss_cmd);
        break;
      end
      @(negedge clk);
    end
    chk(at == exp_at && bk == exp_bank && cm == int'(exp_cmd),
        $sformatf("%s cycle/bank/cmd %0d/%0d/%0d vs", tag, at, bk, cm),
        at, exp_at);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(!iss_valid && iss_cmd == C_NONE, "R10 R11 idle after reset", int'(iss_valid), 0);
    chk(bank_rp_busy == '0, "R10 rp_busy clear after reset", int'(bank_rp_busy), 0);
    @(negedge clk);
    open_row(0, 9); rq(0, 0, 9);
    expect_iss(0, 0, 0, C_RD, "R10 R3 read with cleared counters");
  endtask

  task automatic t_rcd();
    do_reset();
    open_row(1, 4); bank_act[1] = 1'b1;
    @(negedge clk);
    bank_act[1] = 1'b0; rq(1, 0, 4);
    expect_iss(1, T_RCD, 1, C_RD, "R9 read after activation");
  endtask

  task automatic t_ccdl();
    do_reset();
    open_row(0, 5); open_row(1, 5); rq(0, 0, 5); rq(1, 0, 5);
    expect_iss(0, 0, 0, C_RD, "R1 first read bank0");
    @(negedge clk);
    req_valid[0] = 1'b0;
    expect_iss(1, T_CCDL, 1, C_RD, "R5 R2 same-group read spacing");
  endtask

  task automatic t_ccd();
    do_reset();
    open_row(0, 5); open_row(2, 6); rq(0, 0, 5); rq(2, 0, 6);
    expect_iss(0, 0, 0, C_RD, "R3 read bank0");
    @(negedge clk);
    req_valid[0] = 1'b0;
    expect_iss(1, T_CCD, 2, C_RD, "R5 R2 cross-group read spacing");
  endtask

  task automatic t_rtw();
    do_reset();
    open_row(0, 1); open_row(2, 2); rq(0, 0, 1); rq(2, 1, 2);
    expect_iss(0, 0, 0, C_RD, "R3 read before write");
    @(negedge clk);
    req_valid[0] = 1'b0;
    expect_iss(1, T_RTW, 2, C_WR, "R6 R4 read-to-write turnaround");
  endtask

  task automatic t_wtr();
    do_reset();
    open_row(0, 1); open_row(2, 2); rq(0, 1, 1); rq(2, 0, 2);
    expect_iss(0, 0, 0, C_WR, "R4 write before read");
    @(negedge clk);
    req_valid[0] = 1'b0;
    expect_iss(1, T_WTR, 2, C_RD, "R6 write-to-read turnaround");
  endtask

  task automatic t_rtpl_rp();
    do_reset();
    open_row(0, 3); open_row(1, 7); rq(0, 0, 3); rq(1, 0, 8);
    expect_iss(0, 0, 0, C_RD, "R3 read before group precharge");
    @(negedge clk);
    req_valid[0] = 1'b0;
    expect_iss(1, T_RTPL, 1, C_PRE, "R7 group read-to-precharge");
    @(negedge clk);
    req_valid[1] = 1'b0; bank_active[1] = 1'b0;
    #1;
    chk(bank_rp_busy[1], "R8 rp_busy one cycle after precharge", int'(bank_rp_busy[1]), 1);
    @(negedge clk); #1;
    chk(bank_rp_busy[1], "R8 rp_busy tRP-1 cycles after precharge", int'(bank_rp_busy[1]), 1);
    @(negedge clk); #1;
    chk(!bank_rp_busy[1], "R8 rp_busy low tRP cycles after precharge", int'(bank_rp_busy[1]), 0);
  endtask

  task automatic t_ras();
    do_reset();
    open_row(3, 1); bank_act[3] = 1'b1;
    @(negedge clk);
    bank_act[3] = 1'b0; rq(3, 0, 2);
    expect_iss(1, T_RAS, 3, C_PRE, "R7 row-active window before precharge");
  endtask

  task automatic t_wtp();
    do_reset();
    open_row(2, 6); rq(2, 1, 6);
    expect_iss(0, 0, 2, C_WR, "R4 write bank2");
    @(negedge clk);
    rq(2, 1, 7);
    expect_iss(1, T_WTP, 2, C_PRE, "R7 write-to-precharge");
  endtask

  task automatic t_rotate();
    do_reset();
    for (int b = 0; b < NB; b++) begin
      open_row(b, 1); rq(b, 0, 2);
    end
    for (int c = 0; c < NB + 1; c++) begin
      expect_iss(c, c, c % NB, C_PRE, "R1 rotating priority order");
      @(negedge clk);
    end
  endtask

  task automatic t_ignore();
    bit seen = 0;
    do_reset();
    rq(0, 0, 3);
    for (int c = 0; c < 4; c++) begin
      #1; if (iss_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R3 no read to inactive bank", int'(seen), 0);
    req_valid[0] = 1'b0; open_row(0, 3);
    for (int c = 0; c < 4; c++) begin
      #1; if (iss_valid) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R1 no issue without valid request", int'(seen), 0);
    req_valid[0] = 1'b1;
    expect_iss(0, 0, 0, C_RD, "R3 read once request valid");
  endtask

  initial begin
    rst_n = 1'b0;
    clr();
    cfg_tccd = TW'(T_CCD); cfg_tccdl = TW'(T_CCDL); cfg_trcd = TW'(T_RCD);
    cfg_tras = TW'(T_RAS); cfg_trp = TW'(T_RP); cfg_trtpl = TW'(T_RTPL);
    cfg_twtp = TW'(T_WTP); cfg_cl = 6'd5; cfg_wl = 6'd2; cfg_tcdlr = 6'd1;
    cfg_bl = 6'd4;
    t_reset();
    t_rcd();
    t_ccdl();
    t_ccd();
    t_rtw();
    t_wtr();
    t_rtpl_rp();
    t_ras();
    t_wtp();
    t_rotate();
    t_ignore();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule